// File: doc/BRIEF.md
# Pipelined RGB to YUV Colour-Space Converter

This block converts a beat of several pixels from 8-bit red/green/blue samples into 8-bit luma and two chroma samples. Each output channel is a weighted sum of the three input components. The weights are signed integers scaled by 2^15. The sum is divided by 32768 with an arithmetic right shift. The two chroma channels are then raised by 128, and every result is limited to 0..255. All pixels in a beat are independent and are computed side by side, one identical datapath per lane.

The interface is a plain stream. A single valid bit qualifies the whole beat of `LANES` pixels, and the same bit comes out three clock cycles later beside the converted beat. There is no back-pressure: a beat can be presented on every cycle. The internal work is split over three register stages: the nine products per lane, then the three channel sums, then the shift, offset and clamp.

Top module: `rgb2yuv_conv`

## Requirements
- R1: A beat accepted with `in_valid` high at clock edge k appears with `out_valid` high after edge k+3. `out_valid` is low after that edge when `in_valid` was low at edge k. Back-to-back beats keep their order.
- R2: While `rst_n` is low, and until three edges after it is released, `out_valid` is 0. During reset `out_yuv` is all zeros.
- R3: Luma Y = floor((9798·R + 19235·G + 3736·B) / 32768), clamped to 0..255.
- R4: Chroma U = floor((−4784·R − 9437·G + 14221·B) / 32768) + 128, clamped to 0..255.
- R5: Chroma V = floor((20218·R − 16941·G − 3277·B) / 32768) + 128, clamped to 0..255.
- R6: A result above 255 is output as 255 and a result below 0 as 0. Pure red (255,0,0) gives V = 255. Pure green (0,255,0) gives V = 0.
- R7: The division rounds toward minus infinity. Pure red gives U = 90, not 91.
- R8: Lane i uses `in_rgb[24i+23:24i]` as {R[23:16], G[15:8], B[7:0]}. It drives `out_yuv[24i+23:24i]` as {Y[23:16], U[15:8], V[7:0]}. Each lane depends only on its own input pixel.
- R9: A cycle with `in_valid` low leaves `out_yuv` unchanged three edges later, whatever is on `in_rgb`.
- R10: A grey pixel (R = G = B = k) gives Y = k and U = V = 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the input beat |
| in_rgb | input | LANES*24 | Input pixels, lane 0 in the low 24 bits |
| out_valid | output | 1 | Qualifies the output beat |
| out_yuv | output | LANES*24 | Converted pixels, lane 0 in the low 24 bits |

## Verification
A wrong coefficient, offset or shift direction shows as a wrong byte in one channel of every lane. It is visible on the third edge after the beat enters. A broken clamp or a truncating shift only shows on saturated colours, so the stimulus includes primaries, secondaries, black, white and grey. A valid pipeline that is one stage short or long moves `out_valid` by a cycle relative to the data. An enable that is wired wrongly lets idle cycles overwrite `out_yuv`. Both of these show within four cycles.

// File: rtl/yuv_pkg.sv
package yuv_pkg;

  localparam int PIX_W   = 8;
  localparam int COEF_W  = 16;
  localparam int FRAC_W  = 15;
  localparam int NCH     = 3;
  localparam int PROD_W  = PIX_W + COEF_W + 1;
  localparam int ACC_W   = PROD_W + 2;
  localparam int LANE_W  = NCH * PIX_W;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  typedef logic [PIX_W-1:0]          pix_t;
  typedef logic signed [COEF_W-1:0]  coef_t;
  typedef logic signed [PROD_W-1:0]  prod_t;
  typedef logic signed [ACC_W-1:0]   acc_t;

  typedef prod_t [NCH-1:0]     prod_row_t;
  typedef prod_row_t [NCH-1:0] prod_mat_t;
  typedef acc_t [NCH-1:0]      acc_vec_t;

  typedef struct packed {
    pix_t r;
    pix_t g;
    pix_t b;
  } rgb_t;

  // Weight of input component col (0=R,1=G,2=B) in output channel ch (0=Y,1=U,2=V)
  function automatic coef_t f_coef(input int ch, input int col);
    coef_t k;
    case ({ch[1:0], col[1:0]})
      4'b0000: k = 16'sd9798;
      4'b0001: k = 16'sd19235;
      4'b0010: k = 16'sd3736;
      4'b0100: k = -16'sd4784;
      4'b0101: k = -16'sd9437;
      4'b0110: k = 16'sd14221;
      4'b1000: k = 16'sd20218;
      4'b1001: k = -16'sd16941;
      4'b1010: k = -16'sd3277;
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic pix_t f_offset(input int ch);
    return (ch == 0) ? pix_t'(0) : pix_t'(128);
  endfunction

  function automatic pix_t f_pix(input rgb_t px, input int col);
    pix_t p;
    case (col)
      0:       p = px.r;
      1:       p = px.g;
      default: p = px.b;
    endcase
    return p;
  endfunction

  function automatic prod_t f_mul(input pix_t p, input coef_t k);
    prod_t a;
    prod_t b;
    a = prod_t'($signed({1'b0, p}));
    b = prod_t'(k);
    return a * b;
  endfunction

  function automatic acc_t f_sum3(input prod_t a, input prod_t b, input prod_t c);
    return acc_t'(a) + acc_t'(b) + acc_t'(c);
  endfunction

  // Floor-divide by 2^FRAC_W, add offset, saturate to one byte
  function automatic pix_t f_finish(input acc_t acc, input pix_t ofs);
    acc_t sh;
    sh = (acc >>> FRAC_W) + acc_t'({1'b0, ofs});
    if (sh < 0)
      return '0;
    else if (sh > acc_t'(PIX_MAX))
      return pix_t'(PIX_MAX);
    else
      return pix_t'(sh);
  endfunction

endpackage

// File: rtl/yuv_valid_pipe.sv
module yuv_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = taps[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[i] <= 1'b0;
      else        taps[i] <= src;
    end
  end

endmodule

// File: rtl/yuv_lane_mul.sv
module yuv_lane_mul
  import yuv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  rgb_t      px,
  output prod_mat_t prod_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (en) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int col = 0; col < NCH; col++) begin
          prod_q[ch][col] <= f_mul(f_pix(px, col), f_coef(ch, col));
        end
      end
    end
  end

endmodule

// File: rtl/yuv_lane_sum.sv
module yuv_lane_sum
  import yuv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  prod_mat_t prod,
  output acc_vec_t  acc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      for (int ch = 0; ch < NCH; ch++) begin
        acc_q[ch] <= f_sum3(prod[ch][0], prod[ch][1], prod[ch][2]);
      end
    end
  end

endmodule

// File: rtl/yuv_lane_out.sv
module yuv_lane_out
  import yuv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  acc_vec_t          acc,
  output logic [LANE_W-1:0] yuv_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yuv_q <= '0;
    end else if (en) begin
      for (int ch = 0; ch < NCH; ch++) begin
        yuv_q[LANE_W-1-PIX_W*ch -: PIX_W] <= f_finish(acc[ch], f_offset(ch));
      end
    end
  end

endmodule

// File: rtl/rgb2yuv_conv.sv
module rgb2yuv_conv
  import yuv_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*24-1:0] in_rgb,
  output logic                out_valid,
  output logic [LANES*24-1:0] out_yuv
);

  localparam int STAGES = 3;

  logic [STAGES-1:0] vtap;
  logic              s1_valid;
  logic              s2_valid;

  yuv_valid_pipe #(.DEPTH(STAGES)) vpipe_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (in_valid),
    .taps  (vtap)
  );

  assign s1_valid  = vtap[0];
  assign s2_valid  = vtap[1];
  assign out_valid = vtap[2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rgb_t      px;
    prod_mat_t prod;
    acc_vec_t  acc;

    assign px = rgb_t'(in_rgb[l*LANE_W +: LANE_W]);

    yuv_lane_mul mul_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_valid),
      .px     (px),
      .prod_q (prod)
    );

    yuv_lane_sum sum_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s1_valid),
      .prod  (prod),
      .acc_q (acc)
    );

    yuv_lane_out out_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s2_valid),
      .acc   (acc),
      .yuv_q (out_yuv[l*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/rgb2yuv_conv_chk.sv
module rgb2yuv_conv_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [LANES*24-1:0] in_rgb,
  input logic                out_valid,
  input logic [LANES*24-1:0] out_yuv,
  input logic                s2_valid
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> !out_valid); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> $stable(out_yuv)); // R9

  AST_GREY_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid, 3)
     && $past(in_rgb[23:16], 3) == $past(in_rgb[15:8], 3)
     && $past(in_rgb[15:8], 3) == $past(in_rgb[7:0], 3))
    |-> (out_yuv[15:8] == 8'd128 && out_yuv[7:0] == 8'd128
         && out_yuv[23:16] == $past(in_rgb[23:16], 3))); // R10

  AST_RED_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(in_valid, 3) && $past(in_rgb[23:0], 3) == 24'hFF0000)
    |-> (out_yuv[7:0] == 8'd255)); // R6

endmodule

bind rgb2yuv_conv rgb2yuv_conv_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/rgb2yuv_conv_tb_top.sv
`timescale 1ns/1ps
module rgb2yuv_conv_tb_top;

  localparam int LANES = 8;
  localparam int W     = LANES * 24;
  localparam int NVEC  = 8;

  // {R, G, B, Y, U, V}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd0,   8'd0,   8'd0,   8'd0,   8'd128, 8'd128},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd128, 8'd128},
    {8'd255, 8'd0,   8'd0,   8'd76,  8'd90,  8'd255},
    {8'd0,   8'd255, 8'd0,   8'd149, 8'd54,  8'd0  },
    {8'd0,   8'd0,   8'd255, 8'd29,  8'd238, 8'd102},
    {8'd0,   8'd255, 8'd255, 8'd178, 8'd165, 8'd0  },
    {8'd100, 8'd100, 8'd100, 8'd100, 8'd128, 8'd128},
    {8'd10,  8'd20,  8'd30,  8'd18,  8'd133, 8'd120}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_rgb = '0;
  logic         out_valid;
  logic [W-1:0] out_yuv;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  rgb2yuv_conv #(.LANES(LANES)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_rgb    (in_rgb),
    .out_valid (out_valid),
    .out_yuv   (out_yuv)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] beat_in(input int k);
    logic [W-1:0] b;
    for (int i = 0; i < LANES; i++) b[i*24 +: 24] = VEC[(k + i) % NVEC][47:24];
    return b;
  endfunction

  function automatic logic [W-1:0] all_lanes(input logic [23:0] px);
    logic [W-1:0] b;
    for (int i = 0; i < LANES; i++) b[i*24 +: 24] = px;
    return b;
  endfunction

  initial begin
    logic [W-1:0] held;
    // reset state
    repeat (3) @(negedge clk);
    chk("R2 out_valid in reset", W'(out_valid), W'(0));
    chk("R2 out_yuv in reset", out_yuv, '0);
    rst_n = 1'b1;

    // table stream: eight back-to-back beats, lanes rotated through the table (R8)
    for (int t = 0; t < NVEC + 4; t++) begin
      @(negedge clk);
      if (t >= 3 && t < NVEC + 3) begin
        chk("R1 out_valid on beat", W'(out_valid), W'(1));
        for (int i = 0; i < LANES; i++) begin
          for (int ch = 0; ch < 3; ch++) begin
            chk(ch == 0 ? "R3 luma" : (ch == 1 ? "R4 chroma U" : "R5 chroma V"),
                W'(out_yuv[i*24 + 16 - 8*ch +: 8]),
                W'(VEC[(t - 3 + i) % NVEC][16 - 8*ch +: 8]));
          end
        end
      end else if (t < 3 || t == NVEC + 3) begin
        chk("R1 out_valid idle", W'(out_valid), W'(0));
      end
      if (t < NVEC) begin
        in_valid = 1'b1;
        in_rgb   = beat_in(t);
      end else begin
        in_valid = 1'b0;
      end
    end

    // single beat latency, clamp and floor rounding
    @(negedge clk);
    in_valid = 1'b1;
    in_rgb   = all_lanes(24'hFF0000);
    @(negedge clk);
    in_valid = 1'b0;
    in_rgb   = all_lanes(24'h00FF00);
    chk("R1 not before 3 edges", W'(out_valid), W'(0));
    @(negedge clk);
    chk("R1 not before 3 edges", W'(out_valid), W'(0));
    @(negedge clk);
    chk("R1 valid at 3 edges", W'(out_valid), W'(1));
    chk("R6 red V saturates high", W'(out_yuv[7:0]), W'(8'd255));
    chk("R7 red U floors", W'(out_yuv[15:8]), W'(8'd90));

    // idle cycles with changing input must not disturb the output
    held = out_yuv;
    for (int k = 0; k < 5; k++) begin
      in_rgb = all_lanes(24'h123456 + 24'(k * 24'h010203));
      @(negedge clk);
    end
    chk("R9 output held while idle", out_yuv, held);
    chk("R9 out_valid low while idle", W'(out_valid), W'(0));

    // green saturates V low
    in_valid = 1'b1;
    in_rgb   = all_lanes(24'h00FF00);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 green V saturates low", W'(out_yuv[LANES*24-17 -: 8]), W'(8'd0));

    // grey gives neutral chroma and luma equal to the grey level
    in_valid = 1'b1;
    in_rgb   = all_lanes(24'h252525);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 grey maps to neutral", out_yuv, all_lanes({8'h25, 8'd128, 8'd128}));

    // reset in flight clears the pipe
    in_valid = 1'b1;
    in_rgb   = all_lanes(24'h808080);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    chk("R2 out_valid after mid reset", W'(out_valid), W'(0));
    chk("R2 out_yuv after mid reset", out_yuv, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 flushed beat not replayed", W'(out_valid), W'(0));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule